// File: doc/BRIEF.md
# Two-Phase Latch Scan Chain

This block is a chain of scan cells for reaching a chip's internal inputs and outputs during test. Two clock phases that never overlap, `phi` and `phib`, move the chain. Each cell holds its place in the chain with a master latch, which is open while `phi` is high, followed by a slave latch, which is open while `phib` is high. One `phi` pulse followed by one `phib` pulse moves every bit one cell further along.

Each cell is one of three kinds:
- An input cell drives a chip input from a holding latch. Raising `loadEn` copies the bit that has been shifted into the cell into that latch.
- An output cell can capture a chip output into the chain when `scanSel` is 1.
- A combined cell does both.

Every cell passes the phases and control strobes on to the next cell, and the last cell's copies leave the block. A test controller shifts a pattern in, pulses `loadEn` to apply it, captures the responses with `scanSel` = 1, and then shifts them out.

Top module: `scan_chain`

## Requirements
- R1: In each cell the master latch follows its shift source only while `phi` is high, and the slave latch follows the master only while `phib` is high. `scanOut` therefore cannot change while `phi` is high.
- R2: `phi` and `phib` are never high together, and the copies that leave the block never overlap either.
- R3: With `scanSel` = 0, one full `phi` pulse followed by one full `phib` pulse moves the chain one cell. `scanIn` enters cell 0, and `scanOut` is the slave of cell N_CELLS-1. A bit shifted in reaches `scanOut` after exactly N_CELLS such cycles.
- R4: The kind of cell i is field `CELL_KINDS[2i+1:2i]`: 0 means input, 1 means output, 2 means combined. The default is 16'hAA50, which makes cells 0 and 1 input cells, cells 2 and 3 output cells, and cells 4 to 7 combined cells. With `scanSel` = 1, output and combined cells load `chipOut[i]`. Input cells ignore the select and keep shifting serially.
- R5: After a capture cycle, `scanOut` gives the captured value of cell N_CELLS-1 first. Each later shift cycle presents the next lower cell, down to cell 0.
- R6: While `loadEn` is high, input and combined cells copy their slave bit to `chipIn[i]`. To place value P on `chipIn`, P[N_CELLS-1] is shifted in first and P[0] last, and then `loadEn` is pulsed.
- R7: While `loadEn` is low, `chipIn` keeps its value through any number of shift or capture cycles.
- R8: `chipIn[i]` of an output cell is always 0.
- R9: `phiOut`, `phibOut`, `scanSelOut` and `loadOut` follow `phi`, `phib`, `scanSel` and `loadEn` through the cell chain.
- R10: While `rstN` is low, every master, slave and holding latch is cleared, so `scanOut` and `chipIn` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Active-low clear of all latches |
| phi | input | 1 | Master phase |
| phib | input | 1 | Slave phase, never overlapping phi |
| scanSel | input | 1 | Shift source select: 0 serial, 1 capture chip outputs |
| loadEn | input | 1 | Opens the holding latches |
| scanIn | input | 1 | Serial data into cell 0 |
| chipOut | input | N_CELLS | Chip output values offered for capture |
| chipIn | output | N_CELLS | Holding latch values driving chip inputs |
| scanOut | output | 1 | Serial data out of the last cell |
| phiOut | output | 1 | Forwarded phi |
| phibOut | output | 1 | Forwarded phib |
| scanSelOut | output | 1 | Forwarded select |
| loadOut | output | 1 | Forwarded load |

## Verification
The checker takes for granted that the two phases never overlap and that `rstN` is released while both phases are low. The hold check in R7 also assumes that `loadEn` is raised only in the gap between pulses and is never held through a phase pulse. The bench's phase task produces each pulse with a full clock of dead time on both sides. It changes `scanIn`, `scanSel` and `loadEn` only while both phases are low, so every stimulus stays inside these assumptions.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [1:0] {
    CELL_IN   = 2'd0,
    CELL_OUT  = 2'd1,
    CELL_BOTH = 2'd2
  } cellKind_e;

  typedef struct packed {
    logic phi;
    logic phib;
    logic capSel;
    logic load;
  } scanStrobes_t;

endpackage

// File: rtl/scan_cell.sv
module scan_cell
  import scan_pkg::*;
#(
  parameter cellKind_e KIND = CELL_BOTH
) (
  input  logic         rstN,
  input  scanStrobes_t strobesIn,
  input  logic         serIn,
  input  logic         chipOutBit,
  output logic         chipInBit,
  output logic         serOut,
  output scanStrobes_t strobesOut
);

  logic shiftSrc;
  logic masterQ;
  logic slaveQ;
  logic holdQ;

  // Shift source: input cells always shift; others may capture.
  generate
    if (KIND == CELL_IN) begin : g_noCapture
      logic unusedCapPin;
      logic unusedCapSel;
      assign unusedCapPin = chipOutBit;
      assign unusedCapSel = strobesIn.capSel;
      assign shiftSrc = serIn;
    end else begin : g_capture
      assign shiftSrc = strobesIn.capSel ? chipOutBit : serIn;
    end
  endgenerate

  // Master latch, open on phi.
  always_latch begin
    if (!rstN)              masterQ <= 1'b0;
    else if (strobesIn.phi) masterQ <= shiftSrc;
  end

  // Slave latch, open on phib.
  always_latch begin
    if (!rstN)               slaveQ <= 1'b0;
    else if (strobesIn.phib) slaveQ <= masterQ;
  end

  // Holding latch only where a chip input is driven.
  generate
    if (KIND == CELL_OUT) begin : g_noHold
      logic unusedLoad;
      assign unusedLoad = strobesIn.load;
      assign holdQ = 1'b0;
    end else begin : g_hold
      always_latch begin
        if (!rstN)               holdQ <= 1'b0;
        else if (strobesIn.load) holdQ <= slaveQ;
      end
    end
  endgenerate

  assign chipInBit  = holdQ;
  assign serOut     = slaveQ;
  assign strobesOut = strobesIn;

endmodule

// File: rtl/scan_dp.sv
module scan_dp
  import scan_pkg::*;
#(
  parameter int                     N_CELLS    = 8,
  parameter logic [2*N_CELLS-1:0]   CELL_KINDS = 16'hAA50
) (
  input  logic               rstN,
  input  scanStrobes_t       headStrobes,
  input  logic               serIn,
  input  logic [N_CELLS-1:0] chipOut,
  output logic [N_CELLS-1:0] chipIn,
  output logic [N_CELLS-1:0] slaveBits,
  output logic               serOut,
  output scanStrobes_t       tailStrobes
);

  localparam int LINKS = N_CELLS + 1;

  scanStrobes_t strobeLink [LINKS];
  logic [LINKS-1:0] serLink;

  assign strobeLink[0] = headStrobes;
  assign serLink[0]    = serIn;

  generate
    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
      scan_cell #(
        .KIND(cellKind_e'(CELL_KINDS[2*i +: 2]))
      ) u_cell (
        .rstN       (rstN),
        .strobesIn  (strobeLink[i]),
        .serIn      (serLink[i]),
        .chipOutBit (chipOut[i]),
        .chipInBit  (chipIn[i]),
        .serOut     (serLink[i+1]),
        .strobesOut (strobeLink[i+1])
      );
    end
  endgenerate

  assign slaveBits   = serLink[LINKS-1:1];
  assign serOut      = serLink[LINKS-1];
  assign tailStrobes = strobeLink[LINKS-1];

endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
(
  input  logic         phi,
  input  logic         phib,
  input  logic         scanSel,
  input  logic         loadEn,
  input  scanStrobes_t tailStrobes,
  output scanStrobes_t headStrobes,
  output logic         phiOut,
  output logic         phibOut,
  output logic         scanSelOut,
  output logic         loadOut
);

  always_comb begin
    headStrobes        = '0;
    headStrobes.phi    = phi;
    headStrobes.phib   = phib;
    headStrobes.capSel = scanSel;
    headStrobes.load   = loadEn;
  end

  assign phiOut     = tailStrobes.phi;
  assign phibOut    = tailStrobes.phib;
  assign scanSelOut = tailStrobes.capSel;
  assign loadOut    = tailStrobes.load;

endmodule

// File: rtl/scan_chain.sv
module scan_chain
  import scan_pkg::*;
#(
  parameter int                   N_CELLS    = 8,
  parameter logic [2*N_CELLS-1:0] CELL_KINDS = 16'hAA50
) (
  input  logic               rstN,
  input  logic               phi,
  input  logic               phib,
  input  logic               scanSel,
  input  logic               loadEn,
  input  logic               scanIn,
  input  logic [N_CELLS-1:0] chipOut,
  output logic [N_CELLS-1:0] chipIn,
  output logic               scanOut,
  output logic               phiOut,
  output logic               phibOut,
  output logic               scanSelOut,
  output logic               loadOut
);

  scanStrobes_t headStrobes;
  scanStrobes_t tailStrobes;
  logic [N_CELLS-1:0] slaveBits;

  scan_ctrl u_ctrl (
    .phi         (phi),
    .phib        (phib),
    .scanSel     (scanSel),
    .loadEn      (loadEn),
    .tailStrobes (tailStrobes),
    .headStrobes (headStrobes),
    .phiOut      (phiOut),
    .phibOut     (phibOut),
    .scanSelOut  (scanSelOut),
    .loadOut     (loadOut)
  );

  scan_dp #(
    .N_CELLS    (N_CELLS),
    .CELL_KINDS (CELL_KINDS)
  ) u_dp (
    .rstN        (rstN),
    .headStrobes (headStrobes),
    .serIn       (scanIn),
    .chipOut     (chipOut),
    .chipIn      (chipIn),
    .slaveBits   (slaveBits),
    .serOut      (scanOut),
    .tailStrobes (tailStrobes)
  );

endmodule

// File: rtl/scan_chain_chk.sv
module scan_chain_chk #(
  parameter int                   N_CELLS    = 8,
  parameter logic [2*N_CELLS-1:0] CELL_KINDS = 16'hAA50
) (
  input logic               rstN,
  input logic               phi,
  input logic               phib,
  input logic               scanSel,
  input logic               loadEn,
  input logic               scanOut,
  input logic [N_CELLS-1:0] chipIn,
  input logic [N_CELLS-1:0] slaveBits,
  input logic               phiOut,
  input logic               phibOut,
  input logic               scanSelOut,
  input logic               loadOut
);

  function automatic logic [N_CELLS-1:0] holdMaskOf();
    logic [N_CELLS-1:0] m;
    for (int i = 0; i < N_CELLS; i++) m[i] = (CELL_KINDS[2*i +: 2] != 2'd1);
    return m;
  endfunction

  localparam logic [N_CELLS-1:0] HOLD_MASK = holdMaskOf();

  logic        soAtRise;
  int unsigned loadEdges;

  always @(posedge phi) soAtRise <= scanOut;

  always @(posedge loadEn or negedge rstN) begin
    if (!rstN) loadEdges <= 0;
    else       loadEdges <= loadEdges + 1;
  end

  assert_slave_opaque_R1: assert property (@(negedge phi) disable iff (!rstN)
    scanOut == soAtRise);

  assert_no_overlap_phi_R2: assert property (@(posedge phi) disable iff (!rstN)
    !phib);

  assert_no_overlap_phib_R2: assert property (@(posedge phib) disable iff (!rstN)
    !phi);

  assert_load_copies_R6: assert property (@(negedge loadEn) disable iff (!rstN)
    ((chipIn ^ slaveBits) & HOLD_MASK) == '0);

  assert_hold_stable_R7: assert property (@(posedge phib) disable iff (!rstN)
    (loadEdges == $past(loadEdges) && !loadEn && !$past(loadEn))
      |-> chipIn == $past(chipIn));

  assert_out_cell_zero_R8: assert property (@(posedge phib) disable iff (!rstN)
    (chipIn & ~HOLD_MASK) == '0);

  assert_forwarding_R9: assert property (@(negedge phib) disable iff (!rstN)
    phibOut == phib && phiOut == phi && scanSelOut == scanSel && loadOut == loadEn);

endmodule

bind scan_chain scan_chain_chk #(
  .N_CELLS    (N_CELLS),
  .CELL_KINDS (CELL_KINDS)
) u_chk (.*);

// File: tb/sim_scan_chain.sv
module sim_scan_chain;

  localparam int          NC        = 8;
  localparam logic [15:0] SIM_KINDS = 16'hAA50;
  localparam logic [7:0]  HOLD_MASK = 8'hF3;   // cells 2,3 are output-only (R8)
  localparam int          NVEC      = 6;
  // {pattern to load, chipOut value to capture}
  localparam logic [15:0] VECS [NVEC] = '{
    16'hA5_3C, 16'hFF_00, 16'h00_FF, 16'h81_7E, 16'h5A_C3, 16'h3C_96 };

  logic clk = 1'b0;
  logic rstN, phi, phib, scanSel, loadEn, scanIn;
  logic [NC-1:0] chipOut, chipIn;
  logic scanOut, phiOut, phibOut, scanSelOut, loadOut;

  int checks = 0;
  int fails  = 0;
  int overlapSeen = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  scan_chain u0 (
    .rstN(rstN), .phi(phi), .phib(phib), .scanSel(scanSel), .loadEn(loadEn),
    .scanIn(scanIn), .chipOut(chipOut), .chipIn(chipIn), .scanOut(scanOut),
    .phiOut(phiOut), .phibOut(phibOut), .scanSelOut(scanSelOut), .loadOut(loadOut)
  );

  always @(negedge clk) if (phiOut && phibOut) overlapSeen++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic stepChain(input logic bitIn, input logic sel);
    scanIn = bitIn; scanSel = sel; tick();
    phi = 1'b1; tick(); phi = 1'b0; tick();
    phib = 1'b1; tick(); phib = 1'b0; tick();
  endtask

  task automatic pulseLoad();
    loadEn = 1'b1; tick(); loadEn = 1'b0; tick();
  endtask

  task automatic shiftPattern(input logic [7:0] pat);
    for (int j = 0; j < NC; j++) stepChain(pat[NC-1-j], 1'b0);
  endtask

  function automatic logic [7:0] capExpect(input logic [7:0] slaves, input logic [7:0] co,
                                            input logic sIn);
    logic [7:0] r;
    for (int i = 0; i < NC; i++) begin
      if (SIM_KINDS[2*i +: 2] == 2'd0) r[i] = (i == 0) ? sIn : slaves[i-1];
      else                             r[i] = co[i];
    end
    return r;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [7:0] held;
    logic [7:0] cap;
    rstN = 1'b0; phi = 1'b0; phib = 1'b0; scanSel = 1'b0; loadEn = 1'b0;
    scanIn = 1'b0; chipOut = 8'hFF;
    repeat (3) tick();
    settle();
    check("R10 reset scanOut", scanOut, 0);
    check("R10 reset chipIn", chipIn, 0);
    tick(); rstN = 1'b1; tick();

    // R9 forwarding of strobes
    scanSel = 1'b1; loadEn = 1'b0; settle();
    check("R9 fwd sel=1", {phiOut, phibOut, scanSelOut, loadOut}, 4'b0010);
    scanSel = 1'b0; loadEn = 1'b1; phi = 1'b0; settle();
    check("R9 fwd load=1", {phiOut, phibOut, scanSelOut, loadOut}, 4'b0001);
    loadEn = 1'b0; tick();
    phi = 1'b1; settle();
    check("R9 fwd phi=1", {phiOut, phibOut, scanSelOut, loadOut}, 4'b1000);
    tick(); phi = 1'b0; tick();
    phib = 1'b1; settle();
    check("R9 fwd phib=1", {phiOut, phibOut, scanSelOut, loadOut}, 4'b0100);
    tick(); phib = 1'b0; tick();

    // R3 / R1: a single 1 travels the chain
    stepChain(1'b1, 1'b0);
    for (int j = 1; j < NC - 1; j++) stepChain(1'b0, 1'b0);
    settle();
    check("R3 not yet at out", scanOut, 0);
    tick();
    scanIn = 1'b0; phi = 1'b1; tick(); settle();
    check("R1 slave opaque during phi", scanOut, 0);
    tick(); phi = 1'b0; tick(); settle();
    check("R1 still opaque between phases", scanOut, 0);
    tick(); phib = 1'b1; tick(); settle();
    check("R3 arrives after N cycles", scanOut, 1);
    tick(); phib = 1'b0; tick();

    // Vector table: load, capture, unload
    held = 8'h00;
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] pat, co;
      pat = VECS[v][15:8];
      co  = VECS[v][7:0];
      shiftPattern(pat);
      settle();
      check("R7 chipIn kept while shifting", chipIn, held);
      pulseLoad(); settle();
      check("R6 pattern applied", chipIn, pat & HOLD_MASK);
      held = pat & HOLD_MASK;
      chipOut = co;
      stepChain(1'b1, 1'b1);
      cap = capExpect(pat, co, 1'b1);
      settle();
      check("R4 capture first bit", scanOut, cap[NC-1]);
      for (int k = 1; k < NC; k++) begin
        stepChain(1'b0, 1'b0);
        settle();
        check("R5 unload order", scanOut, cap[NC-1-k]);
      end
      check("R7 chipIn kept after capture", chipIn, held);
    end

    // R8: all ones leaves output-only cells at 0
    shiftPattern(8'hFF); pulseLoad(); settle();
    check("R8 output cells zero", chipIn & ~HOLD_MASK, 0);
    check("R6 all ones on hold cells", chipIn, HOLD_MASK);

    // R7: toggle data with load low
    shiftPattern(8'h55); stepChain(1'b1, 1'b1); settle();
    check("R7 unchanged by shift and capture", chipIn, HOLD_MASK);

    // R10: reset mid-operation
    tick(); rstN = 1'b0; tick(); settle();
    check("R10 clear chipIn", chipIn, 0);
    check("R10 clear scanOut", scanOut, 0);
    tick(); rstN = 1'b1; tick();

    check("R2 no phase overlap", overlapSeen, 0);
    finishRun();
  end

endmodule